// File: doc/BRIEF.md
# Page-Mapped Address Translator with Access Fault Logic

This block sits between a 24-bit processor address bus and physical memory. It translates the logical page number, which is address bits 21..12, into a physical frame number. It does this through a 1024-entry page map held in internal flops. The map describes a single process at a time. Each entry carries four fields:

- a 10-bit frame;
- a 2-bit status field, where the value 00 means the page is not present;
- a write-enable bit;
- three spare bits that have no function.

The map is loaded by supervisor writes into a small window of the address space. While the block translates an address, it also decides whether the cycle must be ended with a bus error. A bus error is raised in these cases:

- the page is absent;
- user code touches the kernel-only part of the map;
- user code writes a write-protected page;
- user code reaches the upper 4 MB;
- an acknowledge arrives for a user cycle.

All of these checks are held off while the bus is granted to another master.

Both results are registered. A cycle presented on the inputs before a rising clock edge shows its frame number and its fault decision on the outputs after that edge.

Top module: `page_xlate_guard`

## Requirements
- R1: After reset every map entry reads as zero, so every page is absent; `bus_err` and `phys_page` are 0.
- R2: `phys_page` equals the frame field of the entry indexed by `cpu_addr[21:12]`.
- R3: A map load happens when all of the following hold on the same clock edge: `cyc_strobe`=1, `cpu_read`=0, `cpu_super`=1, `bus_granted`=0, and `cpu_addr` lies in 0x400000..0x4007FF. The entry index is `cpu_addr[10:1]`. The fields taken from `cpu_wdata` are: [9:0] frame, [11:10] status, [12] write enable, [15:13] spare. The new entry governs the very next cycle.
- R4: When `cpu_addr[23:22]`=00, the status field is 00, and both `cyc_timing` and `cyc_strobe` are 1, a fault is raised in either mode.
- R5: When `cpu_addr[23:22]`=00, the page index is below `KERN_PAGES`, `cpu_super`=0, and `cyc_timing` and `cyc_strobe` are both 1, a fault is raised.
- R6: When `cpu_addr[23:22]`=00, `cpu_super`=0, `cpu_read`=0, the write-enable bit is 0, and `cyc_timing`=1, a fault is raised. The strobe is not required. Supervisor writes are exempt.
- R7: A user cycle with `cpu_addr[23:22]`=01 and `cyc_strobe`=1 is faulted.
- R8: With `cpu_addr[23]`=0 and `cpu_super`=0, a fault is raised in two cases: `io_ack_pend`=1 together with `cpu_addr[22]`=1, or `data_ack_pend`=1 at any value of bit 22.
- R9: While `bus_granted`=1, no fault is raised.
- R10: No fault is raised when `cpu_addr[23]`=1. No fault is raised for a supervisor cycle with `cpu_addr[22]`=1.
- R11: `bus_err` and `phys_page` change only at a rising edge, and they reflect the inputs present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 24 | Logical byte address |
| cpu_wdata | input | 16 | Write data, used for map loads |
| cpu_super | input | 1 | 1 = supervisor cycle |
| cpu_read | input | 1 | 1 = read, 0 = write |
| cyc_strobe | input | 1 | Address strobe |
| cyc_timing | input | 1 | Cycle timing qualifier |
| bus_granted | input | 1 | Bus is owned by another master |
| io_ack_pend | input | 1 | I/O acknowledge pending |
| data_ack_pend | input | 1 | Data acknowledge pending |
| phys_page | output | 10 | Translated frame number (physical bits 21..12) |
| bus_err | output | 1 | Bus-error request |

## Verification
Both outputs are due exactly one rising edge after the inputs that cause them. The bench drives each cycle at the falling edge. It confirms at that point that the outputs still show the previous cycle's result. It then compares them against the expected values 1 ns after the next rising edge. A map load is folded into the bench's shadow map only after the expected result of the load cycle has been computed. The next cycle is therefore checked against the new entry, which tests the next-access rule.

// File: rtl/mmu_map_pkg.sv
package mmu_map_pkg;
  localparam int unsigned FRAME_W = 10;
  localparam int unsigned STAT_W  = 2;
  localparam int unsigned SPARE_W = 3;

  typedef struct packed {
    logic [SPARE_W-1:0] spare;
    logic               wr_ok;
    logic [STAT_W-1:0]  stat;
    logic [FRAME_W-1:0] frame;
  } map_entry_t;

  localparam int unsigned ENTRY_W = $bits(map_entry_t);

  function automatic logic page_absent(input logic [STAT_W-1:0] s);
    return (s == '0);
  endfunction
endpackage

// File: rtl/map_store.sv
module map_store
  import mmu_map_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  map_entry_t       wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output map_entry_t       rd_entry
);
  map_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_entry;
    end
  end

  assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/map_window.sv
module map_window
  import mmu_map_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned IDX_W     = 10,
  parameter logic [23:0] WIN_BASE  = 24'h400000,
  parameter bit          NEED_SUPER = 1'b1,
  localparam int unsigned WIN_LSB  = IDX_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic              super_mode,
  input  logic              read_cyc,
  input  logic              strobe,
  input  logic              granted,
  output logic              load,
  output logic [IDX_W-1:0]  load_idx,
  output map_entry_t        load_entry
);
  localparam logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LSB];

  logic hit, priv_ok;

  assign hit = (addr[ADDR_W-1:WIN_LSB] == WIN_TAG);

  generate
    if (NEED_SUPER) begin : g_priv
      assign priv_ok = super_mode;
    end else begin : g_open
      assign priv_ok = 1'b1;
    end
  endgenerate

  assign load       = hit && strobe && !read_cyc && priv_ok && !granted;
  assign load_idx   = addr[IDX_W:1];
  assign load_entry = map_entry_t'(wdata);
endmodule

// File: rtl/fault_eval.sv
module fault_eval
  import mmu_map_pkg::*;
#(
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned KERN_PAGES = 64
) (
  input  logic             a23,
  input  logic             a22,
  input  logic [IDX_W-1:0] page_idx,
  input  logic [STAT_W-1:0] stat,
  input  logic             wr_ok,
  input  logic             super_mode,
  input  logic             read_cyc,
  input  logic             strobe,
  input  logic             timing,
  input  logic             granted,
  input  logic             io_ack,
  input  logic             d_ack,
  output logic             fault
);
  localparam logic [IDX_W:0] KERN_LIM = (IDX_W+1)'(KERN_PAGES);

  logic low_space, user_low, kern_hit;
  logic t_absent, t_kern, t_wprot, t_upper, t_ioack, t_dack;

  assign low_space = !a23 && !a22;
  assign user_low  = low_space && !super_mode;
  assign kern_hit  = ({1'b0, page_idx} < KERN_LIM);

  always_comb begin
    t_absent = low_space && page_absent(stat) && timing && strobe;
    t_kern   = user_low && kern_hit && timing && strobe;
    t_wprot  = user_low && !read_cyc && !wr_ok && timing;
    t_upper  = !super_mode && !a23 && a22 && strobe;
    t_ioack  = !super_mode && !a23 && a22 && io_ack;
    t_dack   = !super_mode && !a23 && d_ack;
    fault    = !granted &&
               (t_absent || t_kern || t_wprot || t_upper || t_ioack || t_dack);
  end
endmodule

// File: rtl/page_xlate_guard.sv
module page_xlate_guard
  import mmu_map_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_SH    = 12,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned KERN_PAGES = 64,
  parameter logic [23:0] WIN_BASE   = 24'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic              cpu_super,
  input  logic              cpu_read,
  input  logic              cyc_strobe,
  input  logic              cyc_timing,
  input  logic              bus_granted,
  input  logic              io_ack_pend,
  input  logic              data_ack_pend,
  output logic [FRAME_W-1:0] phys_page,
  output logic              bus_err
);
  logic [IDX_W-1:0] page_idx;
  logic             load;
  logic [IDX_W-1:0] load_idx;
  map_entry_t       load_entry;
  map_entry_t       cur_entry;
  logic             fault_now;
  logic             unused_bits;

  assign page_idx    = cpu_addr[PAGE_SH+IDX_W-1:PAGE_SH];
  assign unused_bits = ^{cur_entry.spare, cpu_addr[0]};

  map_window #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE), .NEED_SUPER(1'b1)
  ) u_win (
    .addr(cpu_addr), .wdata(cpu_wdata), .super_mode(cpu_super),
    .read_cyc(cpu_read), .strobe(cyc_strobe), .granted(bus_granted),
    .load(load), .load_idx(load_idx), .load_entry(load_entry)
  );

  map_store #(.IDX_W(IDX_W)) u_map (
    .clk(clk), .rst_n(rst_n), .wr_en(load), .wr_idx(load_idx),
    .wr_entry(load_entry), .rd_idx(page_idx), .rd_entry(cur_entry)
  );

  fault_eval #(.IDX_W(IDX_W), .KERN_PAGES(KERN_PAGES)) u_fault (
    .a23(cpu_addr[ADDR_W-1]), .a22(cpu_addr[ADDR_W-2]),
    .page_idx(page_idx), .stat(cur_entry.stat), .wr_ok(cur_entry.wr_ok),
    .super_mode(cpu_super), .read_cyc(cpu_read), .strobe(cyc_strobe),
    .timing(cyc_timing), .granted(bus_granted), .io_ack(io_ack_pend),
    .d_ack(data_ack_pend), .fault(fault_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phys_page <= '0;
      bus_err   <= 1'b0;
    end else begin
      phys_page <= cur_entry.frame;
      bus_err   <= fault_now;
    end
  end
endmodule

// File: rtl/page_xlate_guard_checks.sv
module page_xlate_guard_checks #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_super,
  input logic              cyc_strobe,
  input logic              bus_granted,
  input logic              data_ack_pend,
  input logic              bus_err
);
  assert_grant_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_granted |=> !bus_err);

  assert_user_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_super && !bus_granted && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b01 && cyc_strobe)
      |=> bus_err);

  assert_high_space_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[ADDR_W-1] |=> !bus_err);

  assert_super_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_super && cpu_addr[ADDR_W-2]) |=> !bus_err);

  assert_data_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_super && !bus_granted && !cpu_addr[ADDR_W-1] && data_ack_pend) |=> bus_err);
endmodule

bind page_xlate_guard page_xlate_guard_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_super(cpu_super),
  .cyc_strobe(cyc_strobe), .bus_granted(bus_granted),
  .data_ack_pend(data_ack_pend), .bus_err(bus_err)
);

// File: tb/page_xlate_guard_test.sv
`timescale 1ns/1ps
module page_xlate_guard_test;
  localparam int KP = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_super = 1'b0, cpu_read = 1'b1, cyc_strobe = 1'b0, cyc_timing = 1'b0;
  logic        bus_granted = 1'b0, io_ack_pend = 1'b0, data_ack_pend = 1'b0;
  logic [9:0]  phys_page;
  logic        bus_err;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] shadow [1024];
  logic        prev_err = 1'b0;
  logic [9:0]  prev_pg = '0;

  always #2.5 clk = ~clk;

  page_xlate_guard #(.KERN_PAGES(KP)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_super(cpu_super), .cpu_read(cpu_read), .cyc_strobe(cyc_strobe),
    .cyc_timing(cyc_timing), .bus_granted(bus_granted), .io_ack_pend(io_ack_pend),
    .data_ack_pend(data_ack_pend), .phys_page(phys_page), .bus_err(bus_err)
  );

  function automatic string fault_tag(input logic [23:0] a, input logic s, rd, st, tm, bg, ia, da);
    logic [15:0] e = shadow[a[21:12]];
    if (bg) return "R9";
    if (a[23]) return "R10";
    if (!a[22] && e[11:10] == 2'b00 && tm && st) return "R4";
    if (!s && !a[22] && a[21:12] < KP && tm && st) return "R5";
    if (!s && !a[22] && !rd && !e[12] && tm) return "R6";
    if (!s && a[22] && st) return "R7";
    if (!s && ((a[22] && ia) || da)) return "R8";
    return "R10";
  endfunction

  function automatic logic exp_fault(input logic [23:0] a, input logic s, rd, st, tm, bg, ia, da);
    logic [15:0] e = shadow[a[21:12]];
    logic f;
    if (bg || a[23]) return 1'b0;
    f = 1'b0;
    if (!a[22] && e[11:10] == 2'b00 && tm && st) f = 1'b1;
    if (!s && !a[22] && a[21:12] < KP && tm && st) f = 1'b1;
    if (!s && !a[22] && !rd && !e[12] && tm) f = 1'b1;
    if (!s && a[22] && st) f = 1'b1;
    if (!s && a[22] && ia) f = 1'b1;
    if (!s && da) f = 1'b1;
    return f;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [23:0] a, input logic [15:0] d, input logic s, rd, st, tm,
                     input logic bg, ia, da);
    logic ee;
    logic [9:0] ep;
    string tg;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_super = s; cpu_read = rd; cyc_strobe = st;
    cyc_timing = tm; bus_granted = bg; io_ack_pend = ia; data_ack_pend = da;
    #1;
    check("R11 hold err", {31'd0, bus_err}, {31'd0, prev_err});
    check("R11 hold page", {22'd0, phys_page}, {22'd0, prev_pg});
    ee = exp_fault(a, s, rd, st, tm, bg, ia, da);
    ep = shadow[a[21:12]][9:0];
    tg = fault_tag(a, s, rd, st, tm, bg, ia, da);
    if (st && !rd && s && !bg && a[23:11] == 13'h800) shadow[a[10:1]] = d;
    @(posedge clk);
    #1;
    check(tg, {31'd0, bus_err}, {31'd0, ee});
    check("R2 frame", {22'd0, phys_page}, {22'd0, ep});
    prev_err = ee; prev_pg = ep;
  endtask

  task automatic load_entry(input int idx, input logic [15:0] d);
    cyc(24'h400000 | 24'(idx << 1), d, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: reset values
    check("R1 reset err", {31'd0, bus_err}, 32'd0);
    check("R1 reset page", {22'd0, phys_page}, 32'd0);
    // R1/R4: unloaded page is absent even for supervisor
    cyc(24'h003000, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R1 absent after reset", {31'd0, bus_err}, 32'd1);
    // R3: load then use on the next cycle
    load_entry(3, 16'h1555);
    cyc(24'h003010, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 next access", {22'd0, phys_page}, 32'h155);
    // R5: user on kernel page
    cyc(24'h003010, 16'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 kernel page", {31'd0, bus_err}, 32'd1);
    // R6: write-protected user page
    load_entry(100, 16'h0AAA);
    cyc(24'h064000, 16'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 user read ok", {31'd0, bus_err}, 32'd0);
    cyc(24'h064000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 user write no strobe", {31'd0, bus_err}, 32'd1);
    cyc(24'h064000, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 no timing", {31'd0, bus_err}, 32'd0);
    cyc(24'h064000, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 super write", {31'd0, bus_err}, 32'd0);
    // R7 / R8 / R9 / R10
    cyc(24'h420000, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 user upper", {31'd0, bus_err}, 32'd1);
    cyc(24'h520000, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 io ack", {31'd0, bus_err}, 32'd1);
    cyc(24'h064000, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 data ack", {31'd0, bus_err}, 32'd1);
    cyc(24'h420000, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R9 granted", {31'd0, bus_err}, 32'd0);
    cyc(24'hC20000, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R10 a23 high", {31'd0, bus_err}, 32'd0);
    cyc(24'h420000, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R10 super upper", {31'd0, bus_err}, 32'd0);
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 8;
      logic [23:0] a;
      logic [15:0] d = 16'($urandom);
      logic s = 1'($urandom), rd = 1'($urandom), st = ($urandom % 4) != 0;
      logic tm = ($urandom % 4) != 0, bg = ($urandom % 8) == 0;
      logic ia = ($urandom % 6) == 0, da = ($urandom % 10) == 0;
      case (r)
        0, 1, 2, 3: a = {2'b00, 3'b000, 7'($urandom % 128), 12'($urandom)};
        4: begin
          a = 24'h400000 | 24'(($urandom % 128) << 1);
          s = 1'b1; rd = 1'b0; st = 1'b1; da = 1'b0;
        end
        5: a = {2'b01, 22'($urandom)};
        6: a = {1'b1, 23'($urandom)};
        default: a = 24'($urandom);
      endcase
      cyc(a, d, s, rd, st, tm, bg, ia, da);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule